// File: doc/BRIEF.md
# Decimal and ASCII Adjust Unit

This block repairs the result of a binary add, subtract or multiply, or prepares the dividend of a binary divide, so that the 16-bit accumulator holds packed BCD (two digits per byte) or unpacked BCD (one digit per byte) again. It receives the accumulator value together with the incoming carry and half-carry flags and an operation code. It returns the corrected accumulator and the updated flags. The arithmetic that produced the accumulator value is done elsewhere, before this block.

Six adjustments are supported:
- packed correction after an add or after a subtract, with a +6 or -6 nibble fix-up;
- unpacked correction after an add or after a subtract, which carries into or borrows from the high byte;
- a split of a binary byte into two decimal digits after a multiply;
- a join of two unpacked digits into a binary byte before a divide.

Requests come in on a valid/ready input channel. Results leave on a valid/ready output channel through one register stage. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. Its result shows `out_valid` high from the next cycle. While `out_valid` is high and `out_ready` is low, the result stays frozen and `in_ready` is low. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so the block can take one request per cycle.

Top module: `bcd_adjust_unit`

## Requirements
- R1: Op 0 (packed add fix). Let AL be `in_ax[7:0]`. If AL[3:0] > 9 or the half-carry is set, 0x06 is added and `out_af`=1; otherwise `out_af`=0. If the original AL > 0x99 or the carry is set, 0x60 is added and `out_cf`=1; otherwise `out_cf`=0. Example: 0x4C gives 0x52. The high byte passes through unchanged.
- R2: Op 1 (packed subtract fix). The conditions are the same as in R1, but 0x06 and 0x60 are subtracted, and `out_cf` reports the borrow. Example: 0x3B gives 0x35.
- R3: Op 2 (unpacked add fix). If AL[3:0] > 9 or the half-carry is set, AL becomes (AL[3:0]+6) mod 16, AH is incremented and both flags are set. Otherwise AL becomes AL[3:0] and both flags are cleared. Example: 0x006E gives 0x0104.
- R4: Op 3 (unpacked subtract fix). This uses the same condition as R3, with AL = (AL[3:0]-6) mod 16 and AH decremented. Example: 0x00FF with half-carry gives 0xFF09. Example: 0x0004 with no flags is left as 0x0004.
- R5: Op 4 (digit split). AH becomes AL/10 and AL becomes AL mod 10. Example: 0x002D gives 0x0405. Both flags pass through unchanged.
- R6: Op 5 (digit join). AL becomes (AH*10 + AL) mod 256 and AH becomes 0. Example: 0x0305 gives 0x0023. Both flags pass through unchanged.
- R7: After op 2 or op 3, `out_ax[7:4]` is 0 and `out_cf` equals `out_af`.
- R8: Op codes 6 and 7 return the accumulator and both flags unchanged.
- R9: A request accepted at a clock edge shows `out_valid` high after that edge, carrying its result.
- R10: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and the output value and flags hold.
- R11: During reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| in_op | input | 3 | Adjustment select (0..5; 6 and 7 pass through) |
| in_ax | input | 16 | Accumulator, AH in [15:8], AL in [7:0] |
| in_cf | input | 1 | Incoming carry flag |
| in_af | input | 1 | Incoming half-carry flag |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result can be taken |
| out_ax | output | 16 | Corrected accumulator |
| out_cf | output | 1 | Updated carry flag |
| out_af | output | 1 | Updated half-carry flag |

## Verification
Two cases are hard to reach on purpose:
- The packed fix-ups where both nibble corrections apply and the byte wraps, as when 0x9A becomes 0x00 with carry out.
- The unpacked subtract fix that borrows from an AH of zero.

Directed requests with chosen accumulators and flag inputs hit these cases first. A random sweep over every op code and flag combination follows. During the sweep, `out_ready` is toggled randomly, which holds results under back-pressure while new requests are waiting at the input.

// File: rtl/bcd_adj_pkg.sv
package bcd_adj_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int NIB_W  = 4;
  localparam int OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    ADJ_DEC_ADD = 3'd0,
    ADJ_DEC_SUB = 3'd1,
    ADJ_ASC_ADD = 3'd2,
    ADJ_ASC_SUB = 3'd3,
    ADJ_ASC_MUL = 3'd4,
    ADJ_ASC_DIV = 3'd5
  } adj_op_e;

  typedef struct packed {
    logic [WORD_W-1:0] ax;
    logic              cf;
    logic              af;
  } adj_res_t;
endpackage

// File: rtl/bcd_packed_adj.sv
module bcd_packed_adj
  import bcd_adj_pkg::*;
(
  input  logic [BYTE_W-1:0] al_i,
  input  logic              cf_i,
  input  logic              af_i,
  input  logic              sub_i,
  output logic [BYTE_W-1:0] al_o,
  output logic              cf_o,
  output logic              af_o
);
  localparam logic [NIB_W-1:0]  DIGIT_MAX = NIB_W'(9);
  localparam logic [BYTE_W-1:0] PAIR_MAX  = {DIGIT_MAX, DIGIT_MAX};
  localparam logic [BYTE_W-1:0] LO_STEP   = BYTE_W'(6);
  localparam logic [BYTE_W-1:0] HI_STEP   = LO_STEP << NIB_W;

  logic              lo_fix, hi_fix;
  logic [BYTE_W-1:0] corr;

  always_comb begin
    lo_fix = (al_i[NIB_W-1:0] > DIGIT_MAX) || af_i;
    hi_fix = (al_i > PAIR_MAX) || cf_i;
    corr   = (lo_fix ? LO_STEP : '0) | (hi_fix ? HI_STEP : '0);
    al_o   = sub_i ? (al_i - corr) : (al_i + corr);
    cf_o   = hi_fix;
    af_o   = lo_fix;
  end
endmodule

// File: rtl/bcd_unpacked_adj.sv
module bcd_unpacked_adj
  import bcd_adj_pkg::*;
(
  input  logic [BYTE_W-1:0] ah_i,
  input  logic [NIB_W-1:0]  lo_i,
  input  logic              af_i,
  input  logic              sub_i,
  output logic [WORD_W-1:0] ax_o,
  output logic              flag_o
);
  localparam logic [NIB_W-1:0] DIGIT_MAX = NIB_W'(9);
  localparam logic [NIB_W-1:0] STEP      = NIB_W'(6);

  logic              fix;
  logic [NIB_W-1:0]  lo_new;
  logic [BYTE_W-1:0] ah_new;

  always_comb begin
    fix    = (lo_i > DIGIT_MAX) || af_i;
    lo_new = sub_i ? (lo_i - STEP) : (lo_i + STEP);
    ah_new = sub_i ? (ah_i - BYTE_W'(1)) : (ah_i + BYTE_W'(1));
    if (fix) ax_o = {ah_new, {(BYTE_W-NIB_W){1'b0}}, lo_new};
    else     ax_o = {ah_i,   {(BYTE_W-NIB_W){1'b0}}, lo_i};
    flag_o = fix;
  end
endmodule

// File: rtl/bcd_digit_conv.sv
module bcd_digit_conv
  import bcd_adj_pkg::*;
(
  input  logic [BYTE_W-1:0] ah_i,
  input  logic [BYTE_W-1:0] al_i,
  input  logic              split_i,
  output logic [WORD_W-1:0] ax_o
);
  localparam int                RADIX       = 10;
  localparam int                RECIP_SHIFT = 11;
  localparam int                RECIP       = ((1 << RECIP_SHIFT) + RADIX - 1) / RADIX;
  localparam int                PROD_W      = BYTE_W + 9;
  localparam logic [BYTE_W-1:0] RADIX_B     = BYTE_W'(RADIX);

  logic [PROD_W-1:0] prod;
  logic [BYTE_W-1:0] quo, rem, joined;

  always_comb begin
    prod   = PROD_W'(al_i) * PROD_W'(RECIP);
    quo    = BYTE_W'(prod >> RECIP_SHIFT);
    rem    = al_i - BYTE_W'(quo * RADIX_B);
    joined = BYTE_W'(ah_i * RADIX_B) + al_i;
    ax_o   = split_i ? {quo, rem} : {{BYTE_W{1'b0}}, joined};
  end
endmodule

// File: rtl/bcd_adjust_unit.sv
module bcd_adjust_unit
  import bcd_adj_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_op,
  input  logic [WORD_W-1:0] in_ax,
  input  logic              in_cf,
  input  logic              in_af,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_ax,
  output logic              out_cf,
  output logic              out_af
);
  logic [BYTE_W-1:0] pk_al;
  logic              pk_cf, pk_af;
  logic [WORD_W-1:0] up_ax, dc_ax;
  logic              up_flag;
  adj_res_t          res, res_q;
  logic              vld_q;

  bcd_packed_adj u_packed (
    .al_i (in_ax[BYTE_W-1:0]), .cf_i(in_cf), .af_i(in_af),
    .sub_i(in_op == ADJ_DEC_SUB),
    .al_o (pk_al), .cf_o(pk_cf), .af_o(pk_af)
  );

  bcd_unpacked_adj u_unpacked (
    .ah_i (in_ax[WORD_W-1:BYTE_W]), .lo_i(in_ax[NIB_W-1:0]), .af_i(in_af),
    .sub_i(in_op == ADJ_ASC_SUB),
    .ax_o (up_ax), .flag_o(up_flag)
  );

  bcd_digit_conv u_digits (
    .ah_i   (in_ax[WORD_W-1:BYTE_W]), .al_i(in_ax[BYTE_W-1:0]),
    .split_i(in_op == ADJ_ASC_MUL),
    .ax_o   (dc_ax)
  );

  always_comb begin
    res = '{ax: in_ax, cf: in_cf, af: in_af};
    case (in_op)
      ADJ_DEC_ADD, ADJ_DEC_SUB:
        res = '{ax: {in_ax[WORD_W-1:BYTE_W], pk_al}, cf: pk_cf, af: pk_af};
      ADJ_ASC_ADD, ADJ_ASC_SUB:
        res = '{ax: up_ax, cf: up_flag, af: up_flag};
      ADJ_ASC_MUL, ADJ_ASC_DIV:
        res = '{ax: dc_ax, cf: in_cf, af: in_af};
      default: ;
    endcase
  end

  assign in_ready = !vld_q || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else if (in_valid && in_ready) begin
      vld_q <= 1'b1;
      res_q <= res;
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign out_valid = vld_q;
  assign out_ax    = res_q.ax;
  assign out_cf    = res_q.cf;
  assign out_af    = res_q.af;
endmodule

// File: rtl/bcd_adjust_unit_chk.sv
module bcd_adjust_unit_chk
  import bcd_adj_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [OP_W-1:0]   in_op,
  input logic [WORD_W-1:0] in_ax,
  input logic              in_cf,
  input logic              in_af,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_ax,
  input logic              out_cf,
  input logic              out_af
);
  logic take;
  assign take = in_valid && in_ready;

  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_ax) && $stable(out_cf) && $stable(out_af));

  p_stall_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_ascii_form_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take && (in_op == ADJ_ASC_ADD || in_op == ADJ_ASC_SUB) |=>
      out_ax[BYTE_W-1:NIB_W] == '0 && out_cf == out_af);

  p_digit_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_op == ADJ_ASC_MUL |=>
      out_ax[BYTE_W-1:0] < BYTE_W'(10) && out_cf == $past(in_cf) && out_af == $past(in_af));

  p_join_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_op == ADJ_ASC_DIV |=>
      out_ax[WORD_W-1:BYTE_W] == '0 && out_cf == $past(in_cf) && out_af == $past(in_af));

  p_passthru_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_op > OP_W'(5) |=>
      out_ax == $past(in_ax) && out_cf == $past(in_cf) && out_af == $past(in_af));
endmodule

bind bcd_adjust_unit bcd_adjust_unit_chk u_chk (.*);

// File: tb/bcd_adjust_unit_bench.sv
module bcd_adjust_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = '0;
  logic [15:0] in_ax = '0;
  logic        in_cf = 1'b0, in_af = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_ax;
  logic        out_cf, out_af;

  int  n_chk = 0, n_fail = 0;
  bit  rand_ready = 1'b0;
  bit  done = 1'b0;

  typedef struct {
    logic [15:0] ax;
    logic        cf;
    logic        af;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  bcd_adjust_unit u_bcd_adjust_unit (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  function automatic logic [17:0] model(input int op, input int ax, input bit cf, input bit af);
    int al, ah, r;
    bit lo, hi, c, a;
    al = ax & 255; ah = (ax >> 8) & 255; c = cf; a = af;
    case (op)
      0, 1: begin
        lo = ((al % 16) > 9) || af;
        hi = (al > 153) || cf;
        r = al;
        if (op == 0) r = r + (lo ? 6 : 0) + (hi ? 96 : 0);
        else         r = r + 512 - (lo ? 6 : 0) - (hi ? 96 : 0);
        al = r & 255; c = hi; a = lo;
      end
      2, 3: begin
        lo = ((al % 16) > 9) || af;
        if (lo) begin
          al = (op == 2) ? ((al + 6) & 15) : ((al + 10) & 15);
          ah = (op == 2) ? ((ah + 1) & 255) : ((ah + 255) & 255);
        end else al = al & 15;
        c = lo; a = lo;
      end
      4: begin ah = al / 10; al = al % 10; end
      5: begin al = (ah * 10 + al) & 255; ah = 0; end
      default: ;
    endcase
    return {16'(ah * 256 + al), c, a};
  endfunction

  task automatic send_exp(input int op, input int ax, input bit cf, input bit af,
                          input logic [17:0] e, input string tag);
    bit took;
    sb.push_back('{ax: e[17:2], cf: e[1], af: e[0], tag: tag});
    @(negedge clk);
    in_valid = 1'b1; in_op = 3'(op); in_ax = 16'(ax); in_cf = cf; in_af = af;
    took = 1'b0;
    while (!took) begin
      #1 took = in_ready;
      @(posedge clk);
      if (!took) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    #2 check(out_valid == 1'b1, "R9 result valid after accept", out_valid, 1);
  endtask

  task automatic send(input int op, input int ax, input bit cf, input bit af, input string tag);
    send_exp(op, ax, cf, af, model(op, ax, cf, af), tag);
  endtask

  // monitor: compare at the cycle the output transfer completes
  always begin
    @(negedge clk);
    #2;
    if (rst_n && out_valid && out_ready) begin
      if (sb.size() == 0) check(1'b0, "unexpected output", out_ax, 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        check(out_ax == e.ax && out_cf == e.cf && out_af == e.af, e.tag,
              {out_ax, out_cf, out_af}, {e.ax, e.cf, e.af});
      end
    end
  end

  always @(negedge clk) if (rand_ready) out_ready = ($urandom % 4) != 0;

  initial begin
    #(20 * 100000);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    #2;
    check(out_valid == 1'b0, "R11 out_valid in reset", out_valid, 0);
    check(in_ready == 1'b1, "R11 in_ready in reset", in_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;

    // directed values with constants written out
    send_exp(0, 16'h004C, 0, 0, {16'h0052, 1'b0, 1'b1}, "R1 packed add 4C");
    send_exp(0, 16'h129A, 0, 0, {16'h1200, 1'b1, 1'b1}, "R1 packed add wrap");
    send_exp(0, 16'h0033, 0, 0, {16'h0033, 1'b0, 1'b0}, "R1 packed add no fix");
    send_exp(1, 16'h003B, 0, 1, {16'h0035, 1'b0, 1'b1}, "R2 packed sub 3B");
    send_exp(1, 16'h00F0, 1, 0, {16'h0090, 1'b1, 1'b0}, "R2 packed sub borrow");
    send_exp(2, 16'h006E, 0, 0, {16'h0104, 1'b1, 1'b1}, "R3 unpacked add 6E");
    send_exp(3, 16'h0004, 0, 0, {16'h0004, 1'b0, 1'b0}, "R4 unpacked sub no fix");
    send_exp(3, 16'h00FF, 0, 1, {16'hFF09, 1'b1, 1'b1}, "R4 unpacked sub borrow");
    send_exp(4, 16'h772D, 1, 0, {16'h0405, 1'b1, 1'b0}, "R5 split 2D");
    send_exp(4, 16'h00FF, 0, 1, {16'h1905, 1'b0, 1'b1}, "R5 split FF");
    send_exp(5, 16'h0305, 0, 1, {16'h0023, 1'b0, 1'b1}, "R6 join 0305");
    send_exp(5, 16'h0909, 1, 0, {16'h0063, 1'b1, 1'b0}, "R6 join 0909");
    send_exp(6, 16'h1234, 1, 0, {16'h1234, 1'b1, 1'b0}, "R8 pass op6");
    send_exp(7, 16'hABCD, 0, 1, {16'hABCD, 1'b0, 1'b1}, "R8 pass op7");

    // back-pressure hold
    @(negedge clk);
    out_ready = 1'b0;
    send(0, 16'h0019, 0, 1, "R1 packed add under stall");
    held = out_ax;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      #2;
      check(in_ready == 1'b0, "R10 in_ready low while stalled", in_ready, 0);
      check(out_valid == 1'b1 && out_ax == held, "R10 output held", out_ax, held);
    end
    @(negedge clk);
    out_ready = 1'b1;

    // random sweep with random back-pressure
    rand_ready = 1'b1;
    for (int i = 0; i < 240; i++) begin
      int op;
      string t;
      op = i % 8;
      case (op)
        0: t = "R1 random"; 1: t = "R2 random"; 2: t = "R3 R7 random";
        3: t = "R4 R7 random"; 4: t = "R5 random"; 5: t = "R6 random";
        default: t = "R8 random";
      endcase
      send(op, int'($urandom % 65536), 1'($urandom), 1'($urandom), t);
    end
    @(negedge clk);
    rand_ready = 1'b0;
    out_ready = 1'b1;
    for (int w = 0; w < 20 && sb.size() != 0; w++) @(negedge clk);
    check(sb.size() == 0, "scoreboard drained", sb.size(), 0);
    finish_run();
  end
endmodule